// File: doc/BRIEF.md
# SDRAM Column Burst Sequencer

This block turns one column command for an open SDRAM bank into the stream of per-beat column addresses. It also produces the data-side timing that goes with those addresses. A mode interface, loaded by a strobe, selects the burst length, the wrap order, the CAS latency and a single-write option. Each read or write command supplies an 8-bit start column. The block then emits one column address per clock until the burst ends, a new column command replaces it, or a burst-stop request cuts it short.

On the data side, read beats come back as a read-valid strobe, delayed by the programmed CAS latency. Four byte-mask inputs gate the 8-bit lanes of a 32-bit data bus. For writes they act in the same cycle. For reads they act two clocks later, on the output enables. A write that arrives while read data is still pending takes the bus: the pending read data is dropped from the write cycle onward.

Top module: `sdram_burst_seq`

## Requirements
- R1: While reset is asserted and after it, colValid, rdValid, writeEn and outEn are all low. Until the first mode load, the mode is: length 1, sequential order, CAS latency 2, burst writes.
- R2: Mode inputs are captured only in a cycle with modeLoad high. modeLenCode 0, 1, 2, 3 selects 1, 2, 4 or 8 beats, 7 selects full page (256 beats), and 4 to 6 act as length 1. modeCasLat3 high selects latency 3, low selects latency 2.
- R3: In sequential order, beat k keeps the start column's bits above the low log2(length) bits. Those low bits become (start + k) modulo length. In full page, all 8 bits count up from the start and wrap from 255 to 0.
- R4: In interleaved order with length 2, 4 or 8, beat k is the start column XOR k. With full page selected, the interleave bit is ignored and the order is sequential.
- R5: Beats occupy consecutive cycles, beginning in the command cycle itself. colValid is high for exactly the burst length and then low.
- R6: For every read beat issued in cycle t, rdValid is high in cycle t + latency. With no read beat behind it, rdValid is low again the cycle after.
- R7: In a write beat cycle, writeEn[i] (lane i = data bits 8i+7..8i) is high exactly when byteMask[i] is low in that same cycle.
- R8: outEn[i] is high exactly when rdValid is high and byteMask[i] was low two cycles earlier.
- R9: cmdStop in a cycle without a column command ends the burst: no beat is issued in that cycle or later. Read data issued before the stop still arrives on schedule.
- R10: A column command during a burst starts its own sequence in its command cycle. On a read after a read, data from the earlier beats still arrives at its own latency.
- R11: A write command during pending read data drives rdValid low from the write command cycle on, and the pending read data is discarded.
- R12: With modeSingleWrite set, a write issues exactly one beat, while a read still issues the programmed burst length.
- R13: When cmdValid and cmdStop are high in the same cycle, the column command wins and the stop is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| modeLoad | input | 1 | Captures the mode inputs |
| modeLenCode | input | 3 | Burst length code |
| modeInterleave | input | 1 | 1 = interleaved order, 0 = sequential |
| modeCasLat3 | input | 1 | 1 = CAS latency 3, 0 = CAS latency 2 |
| modeSingleWrite | input | 1 | 1 = writes are one beat |
| cmdValid | input | 1 | Column command this cycle |
| cmdWrite | input | 1 | 1 = write command, 0 = read command |
| cmdStop | input | 1 | Burst-stop request |
| startCol | input | 8 | Start column of the command |
| byteMask | input | 4 | Per-lane mask, high masks the lane |
| colValid | output | 1 | A beat is issued this cycle |
| colAddr | output | 8 | Column address of the current beat |
| rdValid | output | 1 | Read data is on the bus this cycle |
| writeEn | output | 4 | Per-lane write enable of the current beat |
| outEn | output | 4 | Per-lane read output enable |

## Verification
Two things can land in the same cycle here. The first is a burst-stop request together with a new column command. The bench raises both in one cycle during a running burst and requires the new start column to appear at once and keep counting. The second is returning read data together with a write command that takes the bus. The bench places a write exactly in the cycle where an earlier read's data is due, and requires rdValid to stay low in that cycle and in the next one, with all four write enables high.

// File: rtl/sdram_burst_pkg.sv
package sdram_burst_pkg;
  localparam int COL_W  = 8;
  localparam int LANES  = 4;
  localparam int MAX_CL = 3;
  localparam int LEN_CODE_W = 3;
  localparam logic [LEN_CODE_W-1:0] FULL_PAGE_CODE = 3'd7;
  localparam int MAX_POW_CODE = 3;

  typedef struct packed {
    logic [LEN_CODE_W-1:0] lenCode;
    logic                  interleave;
    logic                  casLat3;
    logic                  singleWr;
  } modeReg_t;

  // strobes from control to datapath, valid in the current cycle
  typedef struct packed {
    logic             fire;       // new column command taken now
    logic             beatOn;     // a beat is issued now
    logic             beatWrite;  // the beat is a write
    logic             flushRd;    // write command: drop pending read data
    logic             interleave; // order of the current beat
    logic [COL_W-1:0] beatIdx;    // beat number within the burst
    logic [COL_W-1:0] lowMask;    // wrapping bits of the column
  } beatCtl_t;

  function automatic logic [COL_W-1:0] lowMaskOf(input logic [LEN_CODE_W-1:0] code);
    logic [COL_W-1:0] m;
    m = '0;
    if (code == FULL_PAGE_CODE) m = '1;
    else if (int'(code) <= MAX_POW_CODE) m = COL_W'((1 << code) - 1);
    return m;
  endfunction
endpackage

// File: rtl/sdram_burst_ctrl.sv
module sdram_burst_ctrl
  import sdram_burst_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  modeLoad,
  input  logic [LEN_CODE_W-1:0] modeLenCode,
  input  logic                  modeInterleave,
  input  logic                  modeCasLat3,
  input  logic                  modeSingleWrite,
  input  logic                  cmdValid,
  input  logic                  cmdWrite,
  input  logic                  cmdStop,
  output modeReg_t              modeQ,
  output beatCtl_t              ctl
);
  logic             busy;
  logic [COL_W-1:0] idxQ;
  logic [COL_W-1:0] lastQ;
  logic [COL_W-1:0] maskQ;
  logic             intlQ;
  logic             wrQ;
  logic [COL_W-1:0] newMask;
  logic [COL_W-1:0] newLast;
  logic             newIntl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= '0;
    end else if (modeLoad) begin
      modeQ <= '{lenCode: modeLenCode, interleave: modeInterleave,
                 casLat3: modeCasLat3, singleWr: modeSingleWrite};
    end
  end

  always_comb begin
    newMask = lowMaskOf(modeQ.lenCode);
    newIntl = modeQ.interleave && (modeQ.lenCode != FULL_PAGE_CODE);
    newLast = (cmdWrite && modeQ.singleWr) ? '0 : newMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy  <= 1'b0;
      idxQ  <= '0;
      lastQ <= '0;
      maskQ <= '0;
      intlQ <= 1'b0;
      wrQ   <= 1'b0;
    end else if (cmdValid) begin
      busy  <= (newLast != '0);
      idxQ  <= COL_W'(1);
      lastQ <= newLast;
      maskQ <= newMask;
      intlQ <= newIntl;
      wrQ   <= cmdWrite;
    end else if (busy) begin
      if (cmdStop || idxQ == lastQ) busy <= 1'b0;
      else                          idxQ <= idxQ + 1'b1;
    end
  end

  always_comb begin
    ctl.fire       = cmdValid;
    ctl.beatOn     = cmdValid || (busy && !cmdStop);
    ctl.beatWrite  = cmdValid ? cmdWrite : wrQ;
    ctl.flushRd    = cmdValid && cmdWrite;
    ctl.interleave = cmdValid ? newIntl : intlQ;
    ctl.beatIdx    = cmdValid ? '0 : idxQ;
    ctl.lowMask    = cmdValid ? newMask : maskQ;
  end

  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStop && !cmdValid) |=> !busy);  // R9
  AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdWrite && modeQ.singleWr) |=> !busy);  // R12
endmodule

// File: rtl/sdram_burst_dp.sv
module sdram_burst_dp
  import sdram_burst_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  beatCtl_t         ctl,
  input  logic             casLat3,
  input  logic [COL_W-1:0] startCol,
  input  logic [LANES-1:0] byteMask,
  output logic             colValid,
  output logic [COL_W-1:0] colAddr,
  output logic             rdValid,
  output logic [LANES-1:0] writeEn,
  output logic [LANES-1:0] outEn
);
  logic [COL_W-1:0]  baseQ;
  logic [COL_W-1:0]  base;
  logic [COL_W-1:0]  seqSum;
  logic [MAX_CL-1:0] rdPipe;
  logic              rdIssue;
  logic              rdDue;
  logic [LANES-1:0]  maskDly [2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         baseQ <= '0;
    else if (ctl.fire) baseQ <= startCol;
  end

  always_comb begin
    base   = ctl.fire ? startCol : baseQ;
    seqSum = base + ctl.beatIdx;
    if (ctl.interleave) colAddr = base ^ ctl.beatIdx;
    else                colAddr = (base & ~ctl.lowMask) | (seqSum & ctl.lowMask);
    colValid = ctl.beatOn;
    rdIssue  = ctl.beatOn && !ctl.beatWrite;
  end

  // read-valid delay line; the tap is chosen by the CAS latency
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdPipe <= '0;
    else if (ctl.flushRd) rdPipe <= '0;
    else                  rdPipe <= {rdPipe[MAX_CL-2:0], rdIssue};
  end

  assign rdDue   = casLat3 ? rdPipe[MAX_CL-1] : rdPipe[MAX_CL-2];
  assign rdValid = rdDue && !ctl.flushRd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskDly[0] <= '0;
      maskDly[1] <= '0;
    end else begin
      maskDly[0] <= byteMask;
      maskDly[1] <= maskDly[0];
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign writeEn[g] = ctl.beatOn && ctl.beatWrite && !byteMask[g];
    assign outEn[g]   = rdValid && !maskDly[1][g];
  end

  AST_BUS_ONE_DIR: assert property (@(posedge clk) disable iff (!rstN)
    (|writeEn) |-> !rdValid);  // R11
  AST_ADDR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    colValid |-> ((colAddr & ~ctl.lowMask) == (base & ~ctl.lowMask)));  // R3
  AST_RD_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> ($past(rdIssue, 2) || $past(rdIssue, 3)));  // R6
endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
  import sdram_burst_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        modeLoad,
  input  logic [2:0]  modeLenCode,
  input  logic        modeInterleave,
  input  logic        modeCasLat3,
  input  logic        modeSingleWrite,
  input  logic        cmdValid,
  input  logic        cmdWrite,
  input  logic        cmdStop,
  input  logic [7:0]  startCol,
  input  logic [3:0]  byteMask,
  output logic        colValid,
  output logic [7:0]  colAddr,
  output logic        rdValid,
  output logic [3:0]  writeEn,
  output logic [3:0]  outEn
);
  modeReg_t modeQ;
  beatCtl_t ctl;

  sdram_burst_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .modeLoad(modeLoad), .modeLenCode(modeLenCode),
    .modeInterleave(modeInterleave), .modeCasLat3(modeCasLat3),
    .modeSingleWrite(modeSingleWrite), .cmdValid(cmdValid), .cmdWrite(cmdWrite),
    .cmdStop(cmdStop), .modeQ(modeQ), .ctl(ctl)
  );

  sdram_burst_dp u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .casLat3(modeQ.casLat3),
    .startCol(startCol), .byteMask(byteMask), .colValid(colValid),
    .colAddr(colAddr), .rdValid(rdValid), .writeEn(writeEn), .outEn(outEn)
  );
endmodule

// File: tb/sdram_burst_seq_tb.sv
module sdram_burst_seq_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeLoad = 1'b0, modeInterleave = 1'b0, modeCasLat3 = 1'b0, modeSingleWrite = 1'b0;
  logic [2:0] modeLenCode = 3'd0;
  logic cmdValid = 1'b0, cmdWrite = 1'b0, cmdStop = 1'b0;
  logic [7:0] startCol = 8'h00;
  logic [3:0] byteMask = 4'h0;
  logic colValid, rdValid;
  logic [7:0] colAddr;
  logic [3:0] writeEn, outEn;
  int nChecks = 0;
  int nFail = 0;

  always #10 clk = ~clk;

  sdram_burst_seq u_dut (
    .clk(clk), .rstN(rstN), .modeLoad(modeLoad), .modeLenCode(modeLenCode),
    .modeInterleave(modeInterleave), .modeCasLat3(modeCasLat3),
    .modeSingleWrite(modeSingleWrite), .cmdValid(cmdValid), .cmdWrite(cmdWrite),
    .cmdStop(cmdStop), .startCol(startCol), .byteMask(byteMask),
    .colValid(colValid), .colAddr(colAddr), .rdValid(rdValid),
    .writeEn(writeEn), .outEn(outEn)
  );

  // {lenCode[3], interleave, beats[4], start[8], beat0..beat7 addresses[64]}
  localparam logic [79:0] VEC [8] = '{
    {3'd1, 1'b0, 4'd2, 8'h13, 64'h1312_0000_0000_0000},
    {3'd2, 1'b0, 4'd4, 8'h26, 64'h2627_2425_0000_0000},
    {3'd3, 1'b0, 4'd8, 8'h5D, 64'h5D5E_5F58_595A_5B5C},
    {3'd3, 1'b1, 4'd8, 8'h5D, 64'h5D5C_5F5E_5958_5B5A},
    {3'd2, 1'b1, 4'd4, 8'h81, 64'h8180_8382_0000_0000},
    {3'd1, 1'b1, 4'd2, 8'hFE, 64'hFEFF_0000_0000_0000},
    {3'd0, 1'b0, 4'd1, 8'h40, 64'h4000_0000_0000_0000},
    {3'd5, 1'b0, 4'd1, 8'h33, 64'h3300_0000_0000_0000}
  };

  task automatic checkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic nextCyc();
    @(negedge clk);
    modeLoad = 1'b0; cmdValid = 1'b0; cmdStop = 1'b0; byteMask = 4'h0;
  endtask

  task automatic settle();
    #2;
  endtask

  task automatic loadMode(input logic [2:0] code, input logic il, input logic cl3, input logic sw);
    nextCyc();
    modeLoad = 1'b1; modeLenCode = code; modeInterleave = il;
    modeCasLat3 = cl3; modeSingleWrite = sw;
  endtask

  task automatic issue(input logic wr, input logic [7:0] col);
    cmdValid = 1'b1; cmdWrite = wr; startCol = col;
  endtask

  initial begin
    #4_000_000;
    nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    // R1: reset state, with mode pins set away from the default
    modeLenCode = 3'd3;
    repeat (3) @(posedge clk);
    @(negedge clk); settle();
    checkEq("R1 reset outputs", {colValid, rdValid, writeEn, outEn}, 10'h0);
    rstN = 1'b1;
    nextCyc(); issue(1'b1, 8'h10); settle();
    checkEq("R1 default first beat", {colValid, colAddr}, {1'b1, 8'h10});
    nextCyc(); settle();
    checkEq("R1 default length one", colValid, 1'b0);

    // R3 R4 R5 R7: address order table, walked with write bursts
    for (int v = 0; v < 8; v++) begin
      logic [79:0] e;
      string req;
      e = VEC[v];
      req = e[76] ? "R4 interleaved" : "R3 sequential";
      loadMode(e[79:77], e[76], 1'b0, 1'b0);
      nextCyc(); issue(1'b1, e[71:64]);
      for (int k = 0; k < int'(e[75:72]); k++) begin
        if (k > 0) nextCyc();
        settle();
        checkEq(req, {colValid, colAddr, writeEn}, {1'b1, e[63-8*k -: 8], 4'hF});
      end
      nextCyc(); settle();
      checkEq("R5 burst end", colValid, 1'b0);
    end

    // R2: fields without modeLoad are ignored
    loadMode(3'd2, 1'b0, 1'b0, 1'b0);
    nextCyc(); modeLenCode = 3'd3; issue(1'b1, 8'h00);
    repeat (3) nextCyc();
    nextCyc(); settle();
    checkEq("R2 length kept at 4", colValid, 1'b0);

    // R7: write lane masks in the beat cycle
    loadMode(3'd0, 1'b0, 1'b0, 1'b0);
    nextCyc(); issue(1'b1, 8'h01); byteMask = 4'b1001; settle();
    checkEq("R7 write lanes", writeEn, 4'b0110);

    // R6 R8: CAS latency 2, length 2
    loadMode(3'd1, 1'b0, 1'b0, 1'b0);
    nextCyc(); issue(1'b0, 8'h08); byteMask = 4'b0101; settle();
    checkEq("R6 no data at issue", rdValid, 1'b0);
    nextCyc(); settle(); checkEq("R6 CL2 not early", rdValid, 1'b0);
    nextCyc(); settle();
    checkEq("R8 masked lanes CL2", {rdValid, outEn}, {1'b1, 4'b1010});
    nextCyc(); settle();
    checkEq("R8 open lanes CL2", {rdValid, outEn}, {1'b1, 4'hF});
    nextCyc(); settle(); checkEq("R6 CL2 end", rdValid, 1'b0);

    // R6: CAS latency 3
    loadMode(3'd1, 1'b0, 1'b1, 1'b0);
    nextCyc(); issue(1'b0, 8'h08);
    nextCyc(); nextCyc(); settle(); checkEq("R6 CL3 not early", rdValid, 1'b0);
    nextCyc(); settle(); checkEq("R6 CL3 first", rdValid, 1'b1);
    nextCyc(); settle(); checkEq("R6 CL3 second", rdValid, 1'b1);
    nextCyc(); settle(); checkEq("R6 CL3 end", rdValid, 1'b0);

    // R9: stop after three read beats, CL2, length 8
    loadMode(3'd3, 1'b0, 1'b0, 1'b0);
    nextCyc(); issue(1'b0, 8'h00);
    nextCyc(); nextCyc();
    nextCyc(); cmdStop = 1'b1; settle();
    checkEq("R9 no beat at stop", colValid, 1'b0);
    nextCyc(); settle();
    checkEq("R9 flight data kept", {colValid, rdValid}, {1'b0, 1'b1});
    nextCyc(); settle(); checkEq("R9 data ends", rdValid, 1'b0);

    // R13: command and stop together, length 4 writes
    loadMode(3'd2, 1'b0, 1'b0, 1'b0);
    nextCyc(); issue(1'b1, 8'h20);
    nextCyc(); issue(1'b1, 8'h30); cmdStop = 1'b1; settle();
    checkEq("R13 command wins", {colValid, colAddr}, {1'b1, 8'h30});
    nextCyc(); settle();
    checkEq("R13 burst continues", {colValid, colAddr}, {1'b1, 8'h31});
    repeat (3) nextCyc();

    // R10: read after read, CL3, length 4
    loadMode(3'd2, 1'b0, 1'b1, 1'b0);
    nextCyc(); issue(1'b0, 8'h00);
    nextCyc();
    nextCyc(); issue(1'b0, 8'h40); settle();
    checkEq("R10 cut to new start", colAddr, 8'h40);
    nextCyc(); settle(); checkEq("R10 new sequence", colAddr, 8'h41);
    nextCyc(); settle(); checkEq("R10 old data flows", rdValid, 1'b1);
    nextCyc(); nextCyc(); settle(); checkEq("R10 new burst done", colValid, 1'b0);
    nextCyc(); nextCyc(); settle(); checkEq("R10 last new data", rdValid, 1'b1);
    nextCyc(); settle(); checkEq("R10 data ends", rdValid, 1'b0);

    // R11: write lands on the cycle of due read data, CL2
    loadMode(3'd1, 1'b0, 1'b0, 1'b0);
    nextCyc(); issue(1'b0, 8'h00);
    nextCyc();
    nextCyc(); issue(1'b1, 8'h50); settle();
    checkEq("R11 write takes bus", {rdValid, writeEn}, {1'b0, 4'hF});
    nextCyc(); settle(); checkEq("R11 read discarded", rdValid, 1'b0);

    // R12: single write against an 8-beat read
    loadMode(3'd3, 1'b0, 1'b0, 1'b1);
    nextCyc(); issue(1'b1, 8'h70);
    nextCyc(); settle(); checkEq("R12 one write beat", colValid, 1'b0);
    nextCyc(); issue(1'b0, 8'h70);
    repeat (7) nextCyc();
    settle(); checkEq("R12 read eighth beat", {colValid, colAddr}, {1'b1, 8'h77});
    nextCyc(); settle(); checkEq("R12 read ends", colValid, 1'b0);

    // R3 R4: full page, sequential and with interleave bit set
    for (int il = 0; il < 2; il++) begin
      loadMode(3'd7, il[0], 1'b0, 1'b0);
      nextCyc(); issue(1'b1, 8'hFE);
      for (int k = 1; k <= 256; k++) begin
        nextCyc(); settle();
        if (k == 2)   checkEq(il ? "R4 full page sequential" : "R3 full page wrap",
                              {colValid, colAddr}, {1'b1, 8'h00});
        if (k == 255) checkEq("R3 full page last", {colValid, colAddr}, {1'b1, 8'hFD});
        if (k == 256) checkEq("R5 full page end", colValid, 1'b0);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule